// File: doc/BRIEF.md
# Power Button Wake Status Logic

This block turns a press of an active-low power button into a sticky status flag. It drives two outputs from that flag. The first is a power-management event, raised only while software has enabled it. The second is a supply-on drive that pulls the system out of soft-off whether or not the event is enabled. The button input is resynchronised through a flip-flop chain. A press counts on the high-to-low transition of the resynchronised level, so a button that stays down is recorded once.

Software sees three byte registers. Offset 0 is a status byte that is entirely reserved. Offset 1 is the live status byte: the button flag sits in bit 0, and a wake-issued flag sits in bit 7. Both flags are cleared by writing a one to them. Offset 2 is a control byte whose bit 0 enables the event. The button flag is kept in the battery-backed domain, so only the battery reset clears it. The wake flag, the enable bit, the synchroniser and the read register are reset by the standby-supply reset.

Top module: `pwrbtn_wake`

## Requirements
- R1: A falling edge of the synchronised button input sets bit 0 of the byte at offset 1. Holding the button down does not set the bit again after software has cleared it; a new press is needed.
- R2: A write to offset 1 with bit 0 set clears the button flag. A write with bit 0 at 0 leaves the flag unchanged.
- R3: When a press sets the button flag in the same cycle that a one is written to clear it, the flag ends up set.
- R4: The battery reset clears the button flag to 0. A standby reset on its own leaves the flag unchanged.
- R5: `pme_drv` is 1 exactly while the button flag and the enable bit (bit 0 of offset 2) are both 1.
- R6: A press while `soft_off` is 1 raises `ps_on_drv` whatever the enable bit holds. `ps_on_drv` stays high until `soft_off` falls and is never raised by a press while `soft_off` is 0.
- R7: The byte at offset 0 always reads 0x00, and writes to it have no effect.
- R8: Bit 7 of offset 1 is set whenever a press raises `ps_on_drv`. Writing a one to bit 7 clears it. The standby reset clears it; the battery reset does not.
- R9: The enable bit reads and writes at bit 0 of offset 2 and resets to 0 on the standby reset. All other bits of every byte, and all of offset 3, read 0.
- R10: `reg_rdata` loads the addressed byte on the clock edge that samples `reg_rd`, holds it otherwise, and is 0x00 after the standby reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| bat_rst_n | input | 1 | Battery-domain power-on reset, active low |
| stby_rst_n | input | 1 | Standby-supply power-on reset, active low |
| pb_in_n | input | 1 | Power button, active low, asynchronous |
| soft_off | input | 1 | System is in soft-off with the supply-on line floated |
| reg_addr | input | ADDR_W (2) | Byte offset of the register access |
| reg_wr | input | 1 | Byte write strobe |
| reg_wdata | input | DATA_W (8) | Write data |
| reg_rd | input | 1 | Byte read strobe |
| reg_rdata | output | DATA_W (8) | Registered read data |
| pme_drv | output | 1 | Drive enable for the active-low open-drain event line |
| ps_on_drv | output | 1 | Drive enable that pulls the active-low supply-on line low |

## Verification
Two things can land on the button flag in the same clock edge: a hardware set from a detected press, and a software write-one-to-clear. The bench counts edges through the two-flop synchroniser. It places the clearing write so that it is sampled on exactly the edge that records the press, then reads the flag back through offset 1 and expects it set. A second collision, where a clear is written while the button is still held down, checks that the old press is not counted again.

// File: rtl/pwrbtn_pkg.sv
package pwrbtn_pkg;
  // Register offsets (byte addresses within the block window)
  localparam int unsigned OFS_STAT_LO = 0;
  localparam int unsigned OFS_STAT_HI = 1;
  localparam int unsigned OFS_CTRL    = 2;

  // Bit positions inside the bytes
  localparam int unsigned BIT_PB   = 0;
  localparam int unsigned BIT_WAKE = 7;
  localparam int unsigned BIT_EN   = 0;

  // Sticky write-one-to-clear update: a hardware set outranks a clear.
  function automatic logic sticky_next(input logic cur, input logic set, input logic clr);
    return set | (cur & ~clr);
  endfunction

  // Supply-on drive: captured by a press in soft-off, dropped once the system is up.
  function automatic logic wake_next(input logic cur, input logic press, input logic off);
    return off & (cur | press);
  endfunction

  // Event line condition.
  function automatic logic pme_cond(input logic stat, input logic en);
    return stat & en;
  endfunction
endpackage

// File: rtl/pwrbtn_sync.sv
module pwrbtn_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din_n,
  output logic level_n,
  output logic fall_evt
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[i] <= 1'b1;
        else        chain_q[i] <= din_n;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[i] <= 1'b1;
        else        chain_q[i] <= chain_q[i-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= chain_q[STAGES-1];
  end

  assign level_n  = chain_q[STAGES-1];
  assign fall_evt = prev_q & ~chain_q[STAGES-1];
endmodule

// File: rtl/pwrbtn_sticky.sv
module pwrbtn_sticky (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic q
);
  import pwrbtn_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else        q <= sticky_next(q, set, clr);
  end
endmodule

// File: rtl/pwrbtn_regs.sv
module pwrbtn_regs #(
  parameter int unsigned ADDR_W = 2,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              reg_rd,
  input  logic              pb_stat,
  input  logic              wake_flag,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              en_bit,
  output logic              clr_pb,
  output logic              clr_wake
);
  import pwrbtn_pkg::*;

  localparam logic [ADDR_W-1:0] A_LO   = ADDR_W'(OFS_STAT_LO);
  localparam logic [ADDR_W-1:0] A_HI   = ADDR_W'(OFS_STAT_HI);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);

  logic              hit_hi, hit_ctrl, hit_lo;
  logic [DATA_W-1:0] rd_val;

  assign hit_lo   = (reg_addr == A_LO);
  assign hit_hi   = (reg_addr == A_HI);
  assign hit_ctrl = (reg_addr == A_CTRL);

  assign clr_pb   = reg_wr & hit_hi & reg_wdata[BIT_PB];
  assign clr_wake = reg_wr & hit_hi & reg_wdata[BIT_WAKE];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   en_bit <= 1'b0;
    else if (reg_wr && hit_ctrl)  en_bit <= reg_wdata[BIT_EN];
  end

  always_comb begin
    rd_val = '0;
    if (hit_hi) begin
      rd_val[BIT_PB]   = pb_stat;
      rd_val[BIT_WAKE] = wake_flag;
    end else if (hit_ctrl) begin
      rd_val[BIT_EN] = en_bit;
    end else if (hit_lo) begin
      rd_val = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_val;
  end
endmodule

// File: rtl/pwrbtn_wake.sv
module pwrbtn_wake #(
  parameter int unsigned ADDR_W      = 2,
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              bat_rst_n,
  input  logic              stby_rst_n,
  input  logic              pb_in_n,
  input  logic              soft_off,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              reg_rd,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              pme_drv,
  output logic              ps_on_drv
);
  import pwrbtn_pkg::*;

  // Named internal events, exposed for the checker
  logic pb_level_n;
  logic press_evt;
  logic wake_set;
  logic pb_stat;
  logic wake_flag;
  logic en_bit;
  logic clr_pb;
  logic clr_wake;
  logic wake_q;

  pwrbtn_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (stby_rst_n),
    .din_n    (pb_in_n),
    .level_n  (pb_level_n),
    .fall_evt (press_evt)
  );

  assign wake_set = press_evt & soft_off;

  pwrbtn_sticky u_pb_stat (
    .clk   (clk),
    .rst_n (bat_rst_n),
    .set   (press_evt),
    .clr   (clr_pb),
    .q     (pb_stat)
  );

  pwrbtn_sticky u_wake_flag (
    .clk   (clk),
    .rst_n (stby_rst_n),
    .set   (wake_set),
    .clr   (clr_wake),
    .q     (wake_flag)
  );

  pwrbtn_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk       (clk),
    .rst_n     (stby_rst_n),
    .reg_addr  (reg_addr),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .reg_rd    (reg_rd),
    .pb_stat   (pb_stat),
    .wake_flag (wake_flag),
    .reg_rdata (reg_rdata),
    .en_bit    (en_bit),
    .clr_pb    (clr_pb),
    .clr_wake  (clr_wake)
  );

  always_ff @(posedge clk or negedge stby_rst_n) begin
    if (!stby_rst_n) wake_q <= 1'b0;
    else             wake_q <= wake_next(wake_q, press_evt, soft_off);
  end

  assign ps_on_drv = wake_q;
  assign pme_drv   = pme_cond(pb_stat, en_bit);
endmodule

// File: rtl/pwrbtn_wake_chk.sv
module pwrbtn_wake_chk #(
  parameter int unsigned ADDR_W = 2,
  parameter int unsigned DATA_W = 8
) (
  input logic              clk,
  input logic              bat_rst_n,
  input logic              stby_rst_n,
  input logic              soft_off,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              reg_rd,
  input logic [DATA_W-1:0] reg_rdata,
  input logic              pme_drv,
  input logic              ps_on_drv,
  input logic              press_evt,
  input logic              pb_stat,
  input logic              en_bit,
  input logic              clr_pb
);
  assert_set_from_press_R1: assert property (@(posedge clk) disable iff (!bat_rst_n || !stby_rst_n)
    $rose(pb_stat) |-> $past(press_evt));

  assert_w1c_clears_R2: assert property (@(posedge clk) disable iff (!bat_rst_n || !stby_rst_n)
    ($past(clr_pb) && !$past(press_evt)) |-> !pb_stat);

  assert_set_wins_R3: assert property (@(posedge clk) disable iff (!bat_rst_n || !stby_rst_n)
    $past(press_evt) |-> pb_stat);

  assert_pme_needs_en_R5: assert property (@(posedge clk) disable iff (!bat_rst_n || !stby_rst_n)
    pme_drv |-> en_bit);

  assert_wake_cause_R6: assert property (@(posedge clk) disable iff (!bat_rst_n || !stby_rst_n)
    $rose(ps_on_drv) |-> $past(soft_off && press_evt));

  assert_wake_drop_R6: assert property (@(posedge clk) disable iff (!bat_rst_n || !stby_rst_n)
    !soft_off |=> !ps_on_drv);

  assert_lo_byte_zero_R7: assert property (@(posedge clk) disable iff (!bat_rst_n || !stby_rst_n)
    ($past(reg_rd) && $past(reg_addr) == '0) |-> reg_rdata == '0);
endmodule

bind pwrbtn_wake pwrbtn_wake_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .bat_rst_n  (bat_rst_n),
  .stby_rst_n (stby_rst_n),
  .soft_off   (soft_off),
  .reg_addr   (reg_addr),
  .reg_rd     (reg_rd),
  .reg_rdata  (reg_rdata),
  .pme_drv    (pme_drv),
  .ps_on_drv  (ps_on_drv),
  .press_evt  (press_evt),
  .pb_stat    (pb_stat),
  .en_bit     (en_bit),
  .clr_pb     (clr_pb)
);

// File: tb/pwrbtn_wake_tb.sv
`timescale 1ns/1ps
module pwrbtn_wake_tb;
  logic       clk = 1'b0;
  logic       bat_rst_n = 1'b0;
  logic       stby_rst_n = 1'b0;
  logic       pb_in_n = 1'b1;
  logic       soft_off = 1'b0;
  logic [1:0] reg_addr = '0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic       reg_rd = 1'b0;
  logic [7:0] reg_rdata;
  logic       pme_drv;
  logic       ps_on_drv;

  int n_chk  = 0;
  int n_fail = 0;

  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #2 clk = ~clk;

  pwrbtn_wake u_dut (
    .clk(clk), .bat_rst_n(bat_rst_n), .stby_rst_n(stby_rst_n), .pb_in_n(pb_in_n),
    .soft_off(soft_off), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rd(reg_rd), .reg_rdata(reg_rdata), .pme_drv(pme_drv), .ps_on_drv(ps_on_drv)
  );

  task automatic tick(); @(negedge clk); endtask

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  // Driver: a read pushes its expected byte; the monitor compares it.
  task automatic rd(input logic [1:0] a, input logic [7:0] exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    reg_addr = a; reg_rd = 1'b1;
    tick();
    reg_rd = 1'b0;
    tick();
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    tick();
    reg_wr = 1'b0;
    tick();
  endtask

  task automatic press();
    pb_in_n = 1'b0;
    repeat (4) tick();
    pb_in_n = 1'b1;
    repeat (3) tick();
  endtask

  // Monitor: R10 read data appears after the edge that samples the strobe
  always @(posedge clk) begin
    if (reg_rd) begin
      #1;
      if (exp_q.size() == 0) check("R10 unexpected read", reg_rdata, 8'hxx);
      else check(tag_q.pop_front(), reg_rdata, exp_q.pop_front());
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    repeat (3) tick();
    bat_rst_n = 1'b1; stby_rst_n = 1'b1;
    tick();
    check("R10 rdata after reset", reg_rdata, 8'h00);
    check("R5 pme idle after reset", {7'd0, pme_drv}, 8'h00);
    check("R6 ps_on idle after reset", {7'd0, ps_on_drv}, 8'h00);
    rd(2'd1, 8'h00, "R4 status byte reset");
    rd(2'd2, 8'h00, "R9 enable reset");
    rd(2'd3, 8'h00, "R9 unused offset");

    // R9 enable read/write, reserved bits zero
    wr(2'd2, 8'hFF);
    rd(2'd2, 8'h01, "R9 enable set, reserved zero");
    wr(2'd2, 8'h00);
    rd(2'd2, 8'h00, "R9 enable cleared");

    // R1 press sets flag; R6 no drive outside soft-off
    press();
    rd(2'd1, 8'h01, "R1 press sets flag");
    check("R5 pme off with enable 0", {7'd0, pme_drv}, 8'h00);
    check("R6 no drive when powered", {7'd0, ps_on_drv}, 8'h00);
    rd(2'd1, 8'h01, "R10 reread holds");

    // R2 write 0 no effect, write 1 clears
    wr(2'd1, 8'h00);
    rd(2'd1, 8'h01, "R2 write zero ignored");
    wr(2'd1, 8'h01);
    rd(2'd1, 8'h00, "R2 write one clears");

    // R1 held button counts once
    pb_in_n = 1'b0;
    repeat (4) tick();
    wr(2'd1, 8'h01);
    repeat (4) tick();
    rd(2'd1, 8'h00, "R1 held button not recounted");
    pb_in_n = 1'b1;
    repeat (3) tick();

    // R5 event needs both flag and enable
    wr(2'd2, 8'h01);
    check("R5 enable alone no event", {7'd0, pme_drv}, 8'h00);
    press();
    check("R5 event with flag and enable", {7'd0, pme_drv}, 8'h01);
    wr(2'd1, 8'h01);
    check("R5 event drops on clear", {7'd0, pme_drv}, 8'h00);
    press();
    wr(2'd2, 8'h00);
    check("R5 event drops on disable", {7'd0, pme_drv}, 8'h00);
    wr(2'd1, 8'h01);

    // R6 soft-off wake regardless of enable; R8 wake flag
    soft_off = 1'b1;
    repeat (2) tick();
    check("R6 no drive before press", {7'd0, ps_on_drv}, 8'h00);
    press();
    check("R6 wake drive in soft-off", {7'd0, ps_on_drv}, 8'h01);
    rd(2'd1, 8'h81, "R8 wake flag and status");
    soft_off = 1'b0;
    tick();
    check("R6 drive drops when on", {7'd0, ps_on_drv}, 8'h00);
    wr(2'd1, 8'h80);
    rd(2'd1, 8'h01, "R8 wake flag write-one-clear");

    // R4 / R8 resets
    soft_off = 1'b1;
    press();
    soft_off = 1'b0;
    tick();
    rd(2'd1, 8'h81, "R8 wake flag set again");
    bat_rst_n = 1'b0; repeat (2) tick(); bat_rst_n = 1'b1; tick();
    rd(2'd1, 8'h80, "R4 battery reset clears flag, R8 kept");
    wr(2'd2, 8'h01);
    press();
    stby_rst_n = 1'b0; repeat (2) tick(); stby_rst_n = 1'b1; tick();
    check("R10 rdata cleared by standby reset", reg_rdata, 8'h00);
    rd(2'd1, 8'h01, "R4 flag survives standby reset, R8 cleared");
    rd(2'd2, 8'h00, "R9 enable cleared by standby reset");

    // R7 low byte
    wr(2'd0, 8'hFF);
    rd(2'd0, 8'h00, "R7 reserved byte reads zero");
    rd(2'd1, 8'h01, "R7 write to reserved byte no effect");
    wr(2'd1, 8'h01);

    // R3 set and clear in the same edge
    pb_in_n = 1'b0;
    tick();
    tick();
    reg_addr = 2'd1; reg_wdata = 8'h01; reg_wr = 1'b1;
    tick();
    reg_wr = 1'b0;
    tick();
    rd(2'd1, 8'h01, "R3 set wins over clear");
    pb_in_n = 1'b1;
    repeat (3) tick();

    repeat (2) tick();
    if (exp_q.size() != 0) check("R10 reads drained", 8'(exp_q.size()), 8'h00);
    summary();
    $finish;
  end
endmodule